// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit clock-control registers and presents their contents as parallel control signals: a 4-bit spread selection code, two output enables and two edge-rate selects. A host reaches it over a clock line and an open-drain data line. The slave detects START and STOP, matches a 7-bit device address, and acknowledges by pulling the data line low. In every other phase it releases the line.

Both bus lines pass through a two-flop synchronizer in the system clock domain. The slave samples data on each rising clock edge and changes its own data output only after a falling edge.

The first byte after a write address is a command byte. Its top bit picks the transfer format. A single-byte access targets the register index held in the low seven bits. A block access starts at register 0 and carries a byte count. Reserved bits cannot be written and read back as zero. The registers come out of reset with defined power-up values.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset `spread_sel`=0, `ref_en`=1, `ref_fast`=1, `clk_en`=1, `clk_fast`=1 and `sda_oe`=0 (line released).
- R2: After START, the slave takes an address byte MSB first. Bits 7:1 are the address and bit 0 is the direction (0 write, 1 read). On a match with `DEV_ADDR`, the slave pulls SDA low through the ninth clock.
- R3: On an address mismatch the slave does not acknowledge. It then ignores all traffic, and changes no register, until the next START.
- R4: A command byte with bit 7 = 1 selects single-byte mode, with bits 6:0 as the register index. The first data byte that follows is written to that index and acknowledged. Any further data bytes in the same transfer get no acknowledge and are discarded.
- R5: A command byte with bit 7 = 0 selects block mode. The next byte is a count N. The following N data bytes are written to registers 0, 1, … and each is acknowledged. Bytes beyond N get no acknowledge and are discarded.
- R6: A single-byte read works as follows: write the command, send a repeated START, then send the read address. The slave then shifts out the register at the commanded index, MSB first, and changes SDA only after SCL falls.
- R7: A block read works as follows: write a block command, send a repeated START, then send the read address. The slave first returns the register count (2 by default), then registers from index 0 upward, for as long as the master acknowledges. After a master not-acknowledge, it releases SDA.
- R8: The register map is as follows. In register 0, bits 3:0 hold the spread code. In register 1, bit 7 is the reference enable, bit 6 is the reference edge rate (1 nominal, 0 slow), bit 4 is the main clock enable and bit 3 is the main edge rate. All other bits, including register 1 bit 5, are reserved: writes to them are dropped and they read 0.
- R9: A STOP at any point returns the slave to idle with SDA released and no partial byte written. A START at any point restarts address reception.
- R10: SDA is taken only at SCL rising edges, so SDA activity while SCL is low has no effect. Register outputs change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| spread_sel | output | 4 | Spread selection code |
| ref_en | output | 1 | Reference output enable |
| ref_fast | output | 1 | Reference edge rate, 1 nominal |
| clk_en | output | 1 | Main clock output enable |
| clk_fast | output | 1 | Main clock edge rate, 1 nominal |

## Verification
The assertions assume that the host moves SCL slowly compared with the system clock. Each SCL level must last several cycles, so that every edge gives one clean pulse after synchronization. They also assume that SDA never changes in the same cycle that SCL changes. The stimulus holds every SCL phase for eight system clocks. It waits two clocks after each falling edge before it touches SDA. It makes START and STOP only while SCL has been high for a full phase. The glitch case toggles SDA only inside the low phase.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_ACK, S_TX, S_RACK
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_CMD, PH_CNT, PH_DATA
  } wr_phase_e;

  // power-up value of each register
  function automatic logic [BYTE_W-1:0] reg_default(int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  // writable bits of each register; all others are reserved
  function automatic logic [BYTE_W-1:0] reg_wmask(int idx);
    case (idx)
      0:       return 8'h0F;
      1:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_bit,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_sh, sda_sh;
  logic [2:0] scl_sh_d, sda_sh_d;

  always_comb begin
    scl_sh_d = {scl_sh[1:0], scl_i};
    sda_sh_d = {sda_sh[1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= scl_sh_d;
      sda_sh <= sda_sh_d;
    end
  end

  // index 1 is the synchronized level, index 2 the one before
  always_comb begin
    scl_rise  = scl_sh[1] & ~scl_sh[2];
    scl_fall  = ~scl_sh[1] & scl_sh[2];
    sda_bit   = sda_sh[1];
    start_det = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
    stop_det  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NREG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [6:0]              wr_idx,
  input  logic [7:0]              wr_data,
  input  logic [6:0]              rd_idx,
  output logic [7:0]              rd_data,
  output logic [NREG-1:0][7:0]    reg_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST  = cfg_pkg::reg_default(g);
    localparam logic [7:0] MASK = cfg_pkg::reg_wmask(g);
    logic [7:0] q, d;
    logic       hit;

    always_comb begin
      hit = wr_en && (wr_idx == 7'(g));
      d   = q;
      if (hit) d = wr_data & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else        q <= d;
    end

    assign reg_q[g] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == 7'(i)) rd_data = reg_q[i];
    end
  end

  // R10: contents move only after a write strobe
  assert_hold_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));
endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_bit,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [6:0] rd_idx,
  input  logic [7:0] rd_data
);
  import cfg_pkg::*;
  localparam logic [7:0] NREG_B = 8'(NREG);

  bus_state_e st_q, st_d;
  wr_phase_e  ph_q, ph_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       ack_q, ack_d;
  logic       rd_q, rd_d;
  logic       byte_q, byte_d;
  logic       done_q, done_d;
  logic       first_q, first_d;
  logic       mack_q, mack_d;
  logic [6:0] ptr_q, ptr_d;
  logic [7:0] rem_q, rem_d;
  logic       send_cnt;
  logic [7:0] tx_load;

  always_comb begin
    send_cnt = !byte_q && first_q;
    tx_load  = send_cnt ? NREG_B : rd_data;
  end

  always_comb begin
    st_d = st_q; ph_d = ph_q; cnt_d = cnt_q; sh_d = sh_q;
    ack_d = ack_q; rd_d = rd_q; byte_d = byte_q; done_d = done_q;
    first_d = first_q; mack_d = mack_q; ptr_d = ptr_q; rem_d = rem_q;
    wr_en = 1'b0; wr_idx = ptr_q; wr_data = sh_q; rd_idx = ptr_q;
    if (stop_det) begin
      st_d = S_IDLE;
    end else if (start_det) begin
      st_d = S_ADDR; cnt_d = 4'd0;
    end else begin
      unique case (st_q)
        S_IDLE: ;
        S_ADDR, S_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_bit};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = 4'd0;
            st_d  = S_ACK;
            if (st_q == S_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                ack_d = 1'b1;
                rd_d  = sh_q[0];
                if (sh_q[0]) first_d = 1'b1;
                else begin ph_d = PH_CMD; done_d = 1'b0; end
              end else begin
                st_d = S_IDLE;
              end
            end else begin
              unique case (ph_q)
                PH_CMD: begin
                  ack_d  = 1'b1;
                  byte_d = sh_q[7];
                  ptr_d  = sh_q[7] ? sh_q[6:0] : 7'd0;
                  ph_d   = sh_q[7] ? PH_DATA : PH_CNT;
                end
                PH_CNT: begin
                  ack_d = 1'b1; rem_d = sh_q; ptr_d = 7'd0; ph_d = PH_DATA;
                end
                default: begin
                  if (byte_q) begin
                    ack_d  = !done_q;
                    wr_en  = !done_q;
                    done_d = 1'b1;
                  end else begin
                    ack_d = (rem_q != 8'd0);
                    wr_en = (rem_q != 8'd0);
                    if (rem_q != 8'd0) begin
                      rem_d = rem_q - 8'd1;
                      ptr_d = ptr_q + 7'd1;
                    end
                  end
                end
              endcase
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rd_q) begin
              sh_d = tx_load; st_d = S_TX; first_d = 1'b0;
              if (!send_cnt) ptr_d = ptr_q + 7'd1;
            end else begin
              st_d = S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) st_d = S_RACK;
            else begin
              sh_d  = {sh_q[6:0], 1'b0};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) mack_d = !sda_bit;
          else if (scl_fall) begin
            if (mack_q) begin
              sh_d = tx_load; st_d = S_TX; cnt_d = 4'd0; first_d = 1'b0;
              if (!send_cnt) ptr_d = ptr_q + 7'd1;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ph_q <= PH_CMD; cnt_q <= 4'd0; sh_q <= 8'h00;
      ack_q <= 1'b0; rd_q <= 1'b0; byte_q <= 1'b0; done_q <= 1'b0;
      first_q <= 1'b0; mack_q <= 1'b0; ptr_q <= 7'd0; rem_q <= 8'd0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; cnt_q <= cnt_d; sh_q <= sh_d;
      ack_q <= ack_d; rd_q <= rd_d; byte_q <= byte_d; done_q <= done_d;
      first_q <= first_d; mack_q <= mack_d; ptr_q <= ptr_d; rem_q <= rem_d;
    end
  end

  always_comb sda_oe = ((st_q == S_ACK) && ack_q) || ((st_q == S_TX) && !sh_q[7]);

  // R9: a STOP always frees the line on the next cycle
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  // R9: a START always frees the line for address reception
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R6: data output moves only after an SCL fall or a bus condition
  assert_oe_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));
  // R5: one strobe per received byte
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 2,
  parameter int         SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [SEL_W-1:0] spread_sel,
  output logic             ref_en,
  output logic             ref_fast,
  output logic             clk_en,
  output logic             clk_fast
);
  logic [1:0] rst_sh;
  logic       rst_s;
  logic       scl_rise, scl_fall, sda_bit, start_det, stop_det;
  logic       wr_en;
  logic [6:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;
  logic [NREG-1:0][7:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_s = rst_sh[1];

  cfg_line_sync u_sync (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_bit(sda_bit),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk(clk), .rst_n(rst_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_bit(sda_bit), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  cfg_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .reg_q(reg_q)
  );

  always_comb begin
    spread_sel = reg_q[0][SEL_W-1:0];
    ref_en     = reg_q[1][7];
    ref_fast   = reg_q[1][6];
    clk_en     = reg_q[1][4];
    clk_fast   = reg_q[1][3];
  end
endmodule

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;
  localparam logic [6:0] DEV = 7'h69;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [3:0] spread_sel;
  logic ref_en, ref_fast, clk_en, clk_fast;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  string      tag_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfg_serial_slave #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .spread_sel(spread_sel), .ref_en(ref_en), .ref_fast(ref_fast),
    .clk_en(clk_en), .clk_fast(clk_fast)
  );

  task automatic push(string tag, logic [7:0] e, logic [7:0] a);
    tag_q.push_back(tag); exp_q.push_back(e); act_q.push_back(a);
  endtask

  // monitor: pops pairs and compares
  initial begin
    forever begin
      @(negedge clk);
      while (tag_q.size() > 0) begin
        string t; logic [7:0] e, a;
        t = tag_q.pop_front(); e = exp_q.pop_front(); a = act_q.pop_front();
        checks++;
        if (e !== a) begin
          fails++;
          $display("FAIL %s act=%0h exp=%0h", t, a, e);
        end
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(HP);
    scl = 1'b1; wait_clk(HP);
    sda_m = 1'b0; wait_clk(HP);
    scl = 1'b0; wait_clk(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(HP);
    scl = 1'b1; wait_clk(HP);
    sda_m = 1'b1; wait_clk(HP);
  endtask

  task automatic send_bits(logic [7:0] v, int n, bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      if (glitch) begin sda_m = ~v[i]; wait_clk(3); end
      sda_m = v[i]; wait_clk(HP);
      scl = 1'b1; wait_clk(HP);
      scl = 1'b0; wait_clk(2);
    end
  endtask

  task automatic wr_byte(logic [7:0] v, bit exp_ack, string tag, bit glitch = 0);
    logic got;
    send_bits(v, 8, glitch);
    sda_m = 1'b1; wait_clk(HP);
    scl = 1'b1; wait_clk(HP / 2);
    got = ~sda_line; wait_clk(HP / 2);
    scl = 1'b0; wait_clk(2);
    push(tag, 8'(exp_ack), 8'(got));
  endtask

  task automatic rd_byte(logic [7:0] exp_v, bit mack, string tag);
    logic [7:0] got;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HP);
      scl = 1'b1; wait_clk(HP / 2);
      got[i] = sda_line; wait_clk(HP / 2);
      scl = 1'b0; wait_clk(2);
    end
    sda_m = ~mack; wait_clk(HP);
    scl = 1'b1; wait_clk(HP);
    scl = 1'b0; wait_clk(2);
    sda_m = 1'b1;
    push(tag, exp_v, got);
  endtask

  task automatic byte_write(logic [6:0] idx, logic [7:0] d, string tag, bit glitch = 0);
    bus_start();
    wr_byte({DEV, 1'b0}, 1, {tag, " addr ack R2"});
    wr_byte({1'b1, idx}, 1, {tag, " cmd ack"});
    wr_byte(d, 1, {tag, " data ack"}, glitch);
    bus_stop();
  endtask

  task automatic byte_read(logic [6:0] idx, logic [7:0] e, string tag);
    bus_start();
    wr_byte({DEV, 1'b0}, 1, {tag, " addr ack"});
    wr_byte({1'b1, idx}, 1, {tag, " cmd ack"});
    bus_start();
    wr_byte({DEV, 1'b1}, 1, {tag, " read addr ack R2"});
    rd_byte(e, 0, tag);
    bus_stop();
  endtask

  task automatic check_outs(logic [3:0] s, logic [3:0] f, string tag);
    wait_clk(4);
    push({tag, " spread"}, 8'(s), 8'(spread_sel));
    push({tag, " flags"}, 8'(f), 8'({ref_en, ref_fast, clk_en, clk_fast}));
    push({tag, " sda released"}, 8'h00, 8'(sda_oe));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check_outs(4'h0, 4'hF, "R1 reset");

    // R4 byte write, R6 byte read, R8 reserved bits of reg0
    byte_write(7'd0, 8'hA5, "R4 wr0");
    check_outs(4'h5, 4'hF, "R4 after wr0");
    byte_read(7'd0, 8'h05, "R6 R8 rd0");

    // R10 glitches while SCL low; R8 reg1 mask, bit5 reserved
    byte_write(7'd1, 8'h27, "R10 wr1", 1);
    check_outs(4'h5, 4'h0, "R10 R8 after wr1");
    byte_read(7'd1, 8'h00, "R8 rd1");

    // R5 block write, extra byte refused
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R5 addr");
    wr_byte(8'h00, 1, "R5 cmd");
    wr_byte(8'h02, 1, "R5 count");
    wr_byte(8'h0C, 1, "R5 d0");
    wr_byte(8'hFF, 1, "R5 d1");
    wr_byte(8'h33, 0, "R5 extra nack");
    bus_stop();
    check_outs(4'hC, 4'hF, "R5 after block");

    // R7 block read: count, reg0, reg1
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R7 addr");
    wr_byte(8'h00, 1, "R7 cmd");
    bus_start();
    wr_byte({DEV, 1'b1}, 1, "R7 raddr");
    rd_byte(8'h02, 1, "R7 count");
    rd_byte(8'h0C, 1, "R7 reg0");
    rd_byte(8'hD8, 0, "R7 reg1");
    push("R7 released after nack", 8'h00, 8'(sda_oe));
    bus_stop();

    // R3 wrong address ignored
    bus_start();
    wr_byte({7'h2A, 1'b0}, 0, "R3 addr nack");
    wr_byte(8'h80, 0, "R3 cmd ignored");
    wr_byte(8'h01, 0, "R3 data ignored");
    bus_stop();
    check_outs(4'hC, 4'hF, "R3 unchanged");

    // R9 stop inside a data byte
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R9 addr");
    wr_byte(8'h80, 1, "R9 cmd");
    send_bits(8'hFF, 3, 0);
    bus_stop();
    check_outs(4'hC, 4'hF, "R9 after stop");

    // R9 start inside a byte, then R4 second data byte refused
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R9 addr2");
    wr_byte(8'h80, 1, "R9 cmd2");
    send_bits(8'hF0, 4, 0);
    bus_start();
    wr_byte({DEV, 1'b0}, 1, "R9 restart addr");
    wr_byte(8'h80, 1, "R9 restart cmd");
    wr_byte(8'h03, 1, "R9 restart data");
    wr_byte(8'h09, 0, "R4 second data nack");
    bus_stop();
    check_outs(4'h3, 4'hF, "R9 R4 after restart");

    wait_clk(10);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule